// File: doc/BRIEF.md
# Operand Shifter with Carry Output

This block is a purely combinational operand shifter of the kind placed in front of a processor's arithmetic unit. It accepts a data word, a three-bit code that selects the kind of shift, an eight-bit shift count and the current carry flag. It returns the shifted word together with the carry the shift produces. Five kinds of shift are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right that passes through the carry flag.

The count may come from an instruction's immediate field or from the low byte of a register. The block therefore honours the full eight-bit range and applies distinct rules at a count of zero, at a count equal to the word width, and above the word width. Internally, one logarithmic rotator serves every shift kind. Masks that depend on the count then clear or sign-fill the vacated bit positions.

Top module: `shf_operand_unit`

## Requirements
- R1: The kind code is 0 for logical left, 1 for logical right, 2 for arithmetic right, 3 for rotate right and 4 for one-place rotate right through carry.
- R2: For kinds 0 to 3, a count of zero returns the data word unchanged, and the carry output equals the carry input.
- R3: Logical left by n, for n from 1 to 31, returns the word shifted left with zeros filled in, and the carry output is input bit 32−n. Logical left by exactly 32 returns zero, and the carry output is input bit 0.
- R4: Logical right by n, for n from 1 to 31, returns the word shifted right with zeros filled in, and the carry output is input bit n−1. Logical right by exactly 32 returns zero, and the carry output is input bit 31.
- R5: Logical left or logical right by any count above 32 returns zero, and the carry output is 0.
- R6: Arithmetic right by n, for n from 1 to 31, fills the vacated upper bits with input bit 31, and the carry output is input bit n−1.
- R7: Arithmetic right by 32 or more sets every result bit to input bit 31, and the carry output is also input bit 31.
- R8: Rotate right by a nonzero count rotates by the count modulo 32, and the carry output is bit 31 of the result. A nonzero multiple of 32 therefore returns the word unchanged, with the carry output equal to input bit 31.
- R9: The one-place rotate through carry ignores the count. It returns the word shifted right by one with the carry input placed in bit 31, and the carry output is input bit 0.
- R10: Kind codes 5, 6 and 7 return the data word unchanged, and the carry output equals the carry input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Data word to shift |
| kind_i | input | 3 | Shift kind code |
| amount_i | input | 8 | Shift count |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The hardest cases to reach are the boundaries of the count. These are the counts just below, at and just above the word width, counts that wrap modulo 32 for rotation, and the largest eight-bit count. In each of these cases the carry comes from a different bit, or from a constant, than it does for an ordinary count.

The stimulus sweeps every kind code, including the unused ones, across the counts 0, 1, 2, 7, 31, 32, 33, 63, 64 and 255. It pairs them with operands whose top and bottom bits differ and with both carry inputs. As a result, every boundary rule is exercised with both polarities of the bit it selects.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SHK_LSL = 3'd0,
    SHK_LSR = 3'd1,
    SHK_ASR = 3'd2,
    SHK_ROR = 3'd3,
    SHK_RRX = 3'd4
  } shk_kind_e;

  // rotate-right distance equivalent to a left shift by n (mod width)
  function automatic logic [4:0] shk_left_as_right(input logic [4:0] n);
    return 5'd0 - n;
  endfunction

  // keep bits where keep is set, fill the rest with the sign bit
  function automatic logic [31:0] shk_sign_fill(input logic [31:0] data,
                                                input logic [31:0] keep,
                                                input logic sign);
    return (data & keep) | ({32{sign}} & ~keep);
  endfunction
endpackage

// File: rtl/shf_amount_class.sv
module shf_amount_class #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amount_i,
  output logic             zero_o,
  output logic             mid_o,
  output logic             full_o,
  output logic             over_o,
  output logic [LOG_W-1:0] low_o
);
  localparam logic [AMT_W-1:0] FULL_CNT = AMT_W'(WIDTH);

  assign zero_o = (amount_i == '0);
  assign full_o = (amount_i == FULL_CNT);
  assign over_o = (amount_i > FULL_CNT);
  assign mid_o  = !zero_o && (amount_i < FULL_CNT);
  assign low_o  = amount_i[LOG_W-1:0];
endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LOG_W-1:0] dist_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [LOG_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = dist_i[k]
      ? {stage[k][STEP-1:0], stage[k][WIDTH-1:STEP]}
      : stage[k];
  end

  assign data_o = stage[LOG_W];
endmodule

// File: rtl/shf_keep_mask.sv
module shf_keep_mask #(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [LOG_W-1:0] count_i,
  output logic [WIDTH-1:0] keep_high_o,
  output logic [WIDTH-1:0] keep_low_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign keep_high_o[i]         = (count_i <= LOG_W'(i));
    assign keep_low_o[WIDTH-1-i]  = (count_i <= LOG_W'(i));
  end
endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [2:0]       kind_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  logic             amt_zero, amt_mid, amt_full, amt_over;
  logic [LOG_W-1:0] amt_low, rot_dist;
  logic [WIDTH-1:0] rotated, keep_high, keep_low;
  logic             sign_bit;

  shf_amount_class #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_class (
    .amount_i (amount_i),
    .zero_o   (amt_zero),
    .mid_o    (amt_mid),
    .full_o   (amt_full),
    .over_o   (amt_over),
    .low_o    (amt_low)
  );

  assign rot_dist = (kind_i == SHK_LSL) ? shk_left_as_right(amt_low) : amt_low;

  shf_rotator #(.WIDTH(WIDTH)) u_rot (
    .data_i (operand_i),
    .dist_i (rot_dist),
    .data_o (rotated)
  );

  shf_keep_mask #(.WIDTH(WIDTH)) u_mask (
    .count_i     (amt_low),
    .keep_high_o (keep_high),
    .keep_low_o  (keep_low)
  );

  assign sign_bit = operand_i[WIDTH-1];

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    case (kind_i)
      SHK_LSL: begin
        if (amt_mid) begin
          result_o = rotated & keep_high;
          carry_o  = rotated[0];
        end else if (amt_full) begin
          result_o = '0;
          carry_o  = operand_i[0];
        end else if (amt_over) begin
          result_o = '0;
          carry_o  = 1'b0;
        end
      end
      SHK_LSR: begin
        if (amt_mid) begin
          result_o = rotated & keep_low;
          carry_o  = rotated[WIDTH-1];
        end else if (amt_full) begin
          result_o = '0;
          carry_o  = sign_bit;
        end else if (amt_over) begin
          result_o = '0;
          carry_o  = 1'b0;
        end
      end
      SHK_ASR: begin
        if (amt_mid) begin
          result_o = shk_sign_fill(rotated, keep_low, sign_bit);
          carry_o  = rotated[WIDTH-1];
        end else if (amt_full || amt_over) begin
          result_o = {WIDTH{sign_bit}};
          carry_o  = sign_bit;
        end
      end
      SHK_ROR: begin
        if (!amt_zero) begin
          result_o = rotated;
          carry_o  = rotated[WIDTH-1];
        end
      end
      SHK_RRX: begin
        result_o = {carry_i, operand_i[WIDTH-1:1]};
        carry_o  = operand_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shf_operand_unit_chk.sv
module shf_operand_unit_chk
  import shf_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [2:0]       kind_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             amt_zero,
  input logic             amt_mid,
  input logic             amt_full,
  input logic             amt_over
);
  always_comb begin
    a_r2_count_class: assert ($onehot({amt_zero, amt_mid, amt_full, amt_over}));
    if (kind_i <= 3'd3 && amt_zero) begin
      a_r2_zero_pass: assert (result_o == operand_i && carry_o == carry_i);
    end
    if ((kind_i == SHK_LSL || kind_i == SHK_LSR) && amt_over) begin
      a_r5_over_clear: assert (result_o == '0 && carry_o == 1'b0);
    end
    if (kind_i == SHK_ASR && amt_mid) begin
      a_r6_sign_kept: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
    end
    if (kind_i == SHK_ASR && (amt_full || amt_over)) begin
      a_r7_sign_flood: assert (result_o == {WIDTH{operand_i[WIDTH-1]}}
                               && carry_o == operand_i[WIDTH-1]);
    end
    if (kind_i == SHK_ROR && !amt_zero) begin
      a_r8_rot_carry: assert (carry_o == result_o[WIDTH-1]);
    end
    if (kind_i == SHK_RRX) begin
      a_r9_through_carry: assert (result_o[WIDTH-1] == carry_i
                                  && result_o[WIDTH-2:0] == operand_i[WIDTH-1:1]
                                  && carry_o == operand_i[0]);
    end
    if (kind_i > 3'd4) begin
      a_r10_unused_pass: assert (result_o == operand_i && carry_o == carry_i);
    end
  end
endmodule

bind shf_operand_unit shf_operand_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .operand_i (operand_i),
  .kind_i    (kind_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .amt_zero  (amt_zero),
  .amt_mid   (amt_mid),
  .amt_full  (amt_full),
  .amt_over  (amt_over)
);

// File: tb/shf_operand_unit_bench.sv
module shf_operand_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand;
  logic [2:0]  kind;
  logic [7:0]  amount;
  logic        cin;
  logic [31:0] result;
  logic        cout;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_operand_unit u_shf_operand_unit (
    .operand_i (operand),
    .kind_i    (kind),
    .amount_i  (amount),
    .carry_i   (cin),
    .result_o  (result),
    .carry_o   (cout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // behavioural reference: returns {carry, result}
  function automatic logic [32:0] model(input int k, input logic [31:0] v,
                                        input int n, input logic c);
    logic [31:0] r;
    logic        co;
    r = v; co = c;
    case (k)
      0: if (n >= 1 && n <= 32) begin
           r = (n == 32) ? 32'd0 : v << n; co = v[32-n];
         end else if (n > 32) begin r = 0; co = 0; end
      1: if (n >= 1 && n <= 32) begin
           r = (n == 32) ? 32'd0 : v >> n; co = v[n-1];
         end else if (n > 32) begin r = 0; co = 0; end
      2: if (n >= 32) begin r = {32{v[31]}}; co = v[31]; end
         else if (n >= 1) begin r = 32'($signed(v) >>> n); co = v[n-1]; end
      3: if (n != 0) begin
           int m = n % 32;
           r = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
           co = r[31];
         end
      4: begin r = {c, v[31:1]}; co = v[0]; end
      default: ;
    endcase
    return {co, r};
  endfunction

  function automatic string tag_of(input int k, input int n);
    if (k == 4) return "R9";
    if (k > 4) return "R10";
    if (n == 0) return "R2";
    if (k <= 1 && n > 32) return "R5";
    if (k == 0) return "R3";
    if (k == 1) return "R4";
    if (k == 2) return (n < 32) ? "R6" : "R7";
    return "R8";
  endfunction

  task automatic apply(input int k, input logic [31:0] v, input int n,
                       input logic c, input string tag);
    logic [32:0] exp;
    @(negedge clk);
    kind = 3'(k); operand = v; amount = 8'(n); cin = c;
    @(posedge clk);
    #1;
    exp = model(k, v, n, c);
    checks++;
    if ({cout, result} !== exp) begin
      errors++;
      $display("FAIL %s kind=%0d n=%0d op=%h cin=%b got c=%b r=%h exp c=%b r=%h",
               tag, k, n, v, c, cout, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    int counts [10] = '{0, 1, 2, 7, 31, 32, 33, 63, 64, 255};
    logic [31:0] ops [5] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_3C3C,
                             32'hFFFF_FFFF, 32'h0000_0000};
    operand = '0; kind = '0; amount = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (result !== 32'd0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle state got r=%h c=%b exp r=0 c=0", result, cout);
    end
    // R1: code values select the documented kinds
    apply(0, 32'h0000_0001, 4, 1'b0, "R1");
    apply(1, 32'h0000_0010, 4, 1'b0, "R1");
    apply(2, 32'h8000_0000, 4, 1'b0, "R1");
    apply(3, 32'h0000_0001, 1, 1'b0, "R1");
    apply(4, 32'h0000_0002, 9, 1'b1, "R1");
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 10; a++)
        for (int o = 0; o < 5; o++)
          for (int c = 0; c < 2; c++)
            apply(k, ops[o], counts[a], 1'(c), tag_of(k, counts[a]));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule